// File: doc/BRIEF.md
# Paged Auxiliary Data RAM Controller

This block sits between an 8-bit CPU core and its external data space. It serves two kinds of data-space access from a 512-byte on-chip RAM. A wide access carries a full 16-bit address. A narrow access carries an 8-bit register-indirect pointer, and its upper address bit comes from a page register. All indirect pointers share that one page register, so it selects one of two 256-byte halves of the RAM for every narrow access.

A programming-mode flag travels with each request. While the flag is set, wide accesses never use the RAM. A wide access also bypasses the RAM when its address is 0200h or higher. Either kind of bypassed access goes out on a miss port to the nonvolatile data region, which lies directly above the RAM. The miss port holds its request until that region answers.

The page register is written and read through a special-function-register port at address 86h. Each access is accepted only while the controller is idle and takes at least two cycles. Completion is signalled by a one-cycle ready pulse carrying the read data.

Top module: `aux_xram_ctrl`

## Requirements
- R1: After reset, `rsp_ready` and `miss_valid` are low, and a read of SFR address 86h returns 00h (page 0).
- R2: A wide access (`req_wide`=1) with `req_iap`=0 and address below 0200h goes to the RAM. `rsp_ready` is high in the cycle after the accepting edge and low in the accepting cycle and in the cycle after the pulse.
- R3: A narrow access (`req_wide`=0) reaches RAM byte {page bit 0, `req_ptr`[7:0]}. Page 0 covers bytes 000h–0FFh and page 1 covers 100h–1FFh. No other page state exists.
- R4: A wide access with address ≥ 0200h, or with `req_iap`=1, raises `miss_valid` in the cycle after acceptance. `miss_addr`, `miss_write` and `miss_wdata` carry the request, and all are held until `miss_ready`. The RAM is left unchanged.
- R5: While `miss_valid` is high, `rsp_ready` follows `miss_ready` in the same cycle and `rsp_rdata` equals `miss_rdata`. In the next cycle `miss_valid` is low.
- R6: A write to SFR address 86h stores data bit 0 as the page. A read there returns {7'b0, page}. SFR writes to any other address leave the page unchanged, and SFR reads at other addresses return 00h.
- R7: A narrow access always uses the RAM, whatever the value of `req_iap`.
- R8: A request presented while an access is in progress is ignored. It changes neither the RAM nor the pending miss.
- R9: A narrow access uses the page value held before its accepting edge. This holds even when an SFR page write lands on the same edge.
- R10: A byte written to the RAM is returned unchanged by a later read of the same address, on `rsp_rdata` during the ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_wide | input | 1 | 1 = 16-bit address access, 0 = 8-bit pointer access |
| req_iap | input | 1 | Programming-mode flag; when 1, wide accesses miss |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr16 | input | 16 | Address for wide accesses |
| req_ptr | input | 8 | Pointer byte for narrow accesses |
| req_wdata | input | 8 | Write data |
| rsp_ready | output | 1 | Access complete |
| rsp_rdata | output | 8 | Read data, valid while `rsp_ready` is high |
| sfr_addr | input | 8 | SFR address |
| sfr_we | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data |
| miss_valid | output | 1 | Forwarded access to the nonvolatile region is pending |
| miss_write | output | 1 | Write flag of the forwarded access |
| miss_addr | output | 16 | Address of the forwarded access |
| miss_wdata | output | 8 | Write data of the forwarded access |
| miss_ready | input | 1 | Nonvolatile region completes the forwarded access |
| miss_rdata | input | 8 | Read data from the nonvolatile region |

## Verification
A request driven before edge k is accepted at edge k. A RAM result is checked one negative edge later: `rsp_ready` must be high and the data must match the bench's byte model. One more negative edge later, `rsp_ready` must be low again. A miss is checked at the negative edge after acceptance, and the bench then holds `miss_ready` low for a chosen number of cycles, confirming each time that the request stays unchanged. It then raises `miss_ready` and samples `rsp_ready`/`rsp_rdata` shortly afterwards in that same cycle, because those outputs follow it combinationally. SFR reads are also combinational and are sampled a short delay after the address is set.

// File: rtl/aux_xram_pkg.sv
package aux_xram_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int PTR_W      = 8;
    localparam int RAM_BYTES  = 512;
    localparam int RAM_AW     = $clog2(RAM_BYTES);
    localparam int PAGE_W     = RAM_AW - PTR_W;
    localparam int SFR_W      = 8;
    localparam logic [SFR_W-1:0] PAGE_SFR_ADDR = 8'h86;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RAM_DONE,
        ST_MISS_WAIT
    } seq_state_e;

    // request as captured at acceptance
    typedef struct packed {
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [ADDR_W-1:0] addr;
    } xreq_t;

    // decoded destination of an access
    typedef struct packed {
        logic              hit;
        logic [RAM_AW-1:0] ram_addr;
    } route_t;

    function automatic route_t route_access(
        input logic              wide,
        input logic              iap,
        input logic [ADDR_W-1:0] a16,
        input logic [PTR_W-1:0]  ptr,
        input logic [PAGE_W-1:0] page
    );
        route_t r;
        if (wide) begin
            r.ram_addr = a16[RAM_AW-1:0];
            r.hit      = !iap && (a16 < ADDR_W'(RAM_BYTES));
        end else begin
            r.ram_addr = {page, ptr};
            r.hit      = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/aux_page_reg.sv
module aux_page_reg
    import aux_xram_pkg::*;
#(
    parameter int               PW       = PAGE_W,
    parameter logic [SFR_W-1:0] REG_ADDR = PAGE_SFR_ADDR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SFR_W-1:0] sfr_addr,
    input  logic             sfr_we,
    input  logic [SFR_W-1:0] sfr_wdata,
    output logic [SFR_W-1:0] sfr_rdata,
    output logic [PW-1:0]    page
);

    localparam int PAD_W = SFR_W - PW;

    logic [PW-1:0] page_q;
    logic          sel;

    assign sel = (sfr_addr == REG_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (sfr_we && sel) begin
            page_q <= sfr_wdata[PW-1:0];
        end
    end

    always_comb begin
        sfr_rdata = '0;
        if (sel) begin
            sfr_rdata = {{PAD_W{1'b0}}, page_q};
        end
    end

    assign page = page_q;

endmodule

// File: rtl/aux_addr_decode.sv
module aux_addr_decode
    import aux_xram_pkg::*;
(
    input  logic              wide,
    input  logic              iap,
    input  logic [ADDR_W-1:0] addr16,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [PAGE_W-1:0] page,
    output route_t            route
);

    always_comb begin
        route = route_access(wide, iap, addr16, ptr, page);
    end

endmodule

// File: rtl/aux_ram_bank.sv
module aux_ram_bank #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata_q <= mem[addr];
            end
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/aux_xram_seq.sv
module aux_xram_seq
    import aux_xram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              hit,
    input  xreq_t             req,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              miss_ready,
    input  logic [DATA_W-1:0] miss_rdata,
    output logic              take,
    output logic              ram_en,
    output logic              ram_we,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              miss_valid,
    output logic              miss_write,
    output logic [ADDR_W-1:0] miss_addr,
    output logic [DATA_W-1:0] miss_wdata
);

    seq_state_e state_q;
    xreq_t      miss_q;

    assign take   = (state_q == ST_IDLE) && req_valid;
    assign ram_en = take && hit;
    assign ram_we = req.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            miss_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (hit) begin
                            state_q <= ST_RAM_DONE;
                        end else begin
                            state_q <= ST_MISS_WAIT;
                            miss_q  <= req;
                        end
                    end
                end
                ST_RAM_DONE: state_q <= ST_IDLE;
                ST_MISS_WAIT: begin
                    if (miss_ready) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        miss_valid = (state_q == ST_MISS_WAIT);
        rsp_ready  = (state_q == ST_RAM_DONE) || (miss_valid && miss_ready);
        rsp_rdata  = miss_valid ? miss_rdata : ram_rdata;
    end

    assign miss_write = miss_q.write;
    assign miss_addr  = miss_q.addr;
    assign miss_wdata = miss_q.wdata;

endmodule

// File: rtl/aux_xram_ctrl.sv
module aux_xram_ctrl
    import aux_xram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_wide,
    input  logic              req_iap,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr16,
    input  logic [PTR_W-1:0]  req_ptr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [SFR_W-1:0]  sfr_addr,
    input  logic              sfr_we,
    input  logic [SFR_W-1:0]  sfr_wdata,
    output logic [SFR_W-1:0]  sfr_rdata,
    output logic              miss_valid,
    output logic              miss_write,
    output logic [ADDR_W-1:0] miss_addr,
    output logic [DATA_W-1:0] miss_wdata,
    input  logic              miss_ready,
    input  logic [DATA_W-1:0] miss_rdata
);

    logic [PAGE_W-1:0] page;
    route_t            route;
    xreq_t             req;
    logic              acc_take;
    logic              acc_hit;
    logic              ram_en;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;

    aux_page_reg u_page (
        .clk       (clk),
        .rst       (rst),
        .sfr_addr  (sfr_addr),
        .sfr_we    (sfr_we),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .page      (page)
    );

    aux_addr_decode u_dec (
        .wide   (req_wide),
        .iap    (req_iap),
        .addr16 (req_addr16),
        .ptr    (req_ptr),
        .page   (page),
        .route  (route)
    );

    always_comb begin
        req.write = req_write;
        req.wdata = req_wdata;
        req.addr  = req_addr16;
        acc_hit   = route.hit;
    end

    aux_xram_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .hit        (acc_hit),
        .req        (req),
        .ram_rdata  (ram_rdata),
        .miss_ready (miss_ready),
        .miss_rdata (miss_rdata),
        .take       (acc_take),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .rsp_ready  (rsp_ready),
        .rsp_rdata  (rsp_rdata),
        .miss_valid (miss_valid),
        .miss_write (miss_write),
        .miss_addr  (miss_addr),
        .miss_wdata (miss_wdata)
    );

    aux_ram_bank #(
        .DEPTH (RAM_BYTES),
        .DW    (DATA_W),
        .AW    (RAM_AW)
    ) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (route.ram_addr),
        .wdata (req_wdata),
        .rdata (ram_rdata)
    );

endmodule

// File: rtl/aux_xram_chk.sv
module aux_xram_chk
    import aux_xram_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              take,
    input logic              hit,
    input logic              rsp_ready,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic [ADDR_W-1:0] miss_addr,
    input logic [SFR_W-1:0]  sfr_addr,
    input logic [SFR_W-1:0]  sfr_rdata
);

    // R2
    ram_ready_next_chk: assert property (@(posedge clk) disable iff (rst)
        take && hit |=> rsp_ready && !miss_valid);

    // R2
    min_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> !rsp_ready);

    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |=> !rsp_ready);

    // R4
    miss_route_chk: assert property (@(posedge clk) disable iff (rst)
        take && !hit |=> miss_valid);

    // R4
    miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
        miss_valid && !miss_ready |=> miss_valid && $stable(miss_addr));

    // R5
    miss_done_chk: assert property (@(posedge clk) disable iff (rst)
        miss_valid && miss_ready |=> !miss_valid);

    // R6
    page_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sfr_addr == PAGE_SFR_ADDR |-> sfr_rdata[SFR_W-1:PAGE_W] == '0);

    // R8
    busy_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        miss_valid || rsp_ready |-> !take);

endmodule

bind aux_xram_ctrl aux_xram_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .take       (acc_take),
    .hit        (acc_hit),
    .rsp_ready  (rsp_ready),
    .miss_valid (miss_valid),
    .miss_ready (miss_ready),
    .miss_addr  (miss_addr),
    .sfr_addr   (sfr_addr),
    .sfr_rdata  (sfr_rdata)
);

// File: tb/aux_xram_ctrl_bench.sv
module aux_xram_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_wide, req_iap, req_write;
    logic [15:0] req_addr16;
    logic [7:0]  req_ptr, req_wdata;
    logic        rsp_ready;
    logic [7:0]  rsp_rdata;
    logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
    logic        sfr_we;
    logic        miss_valid, miss_write;
    logic [15:0] miss_addr;
    logic [7:0]  miss_wdata;
    logic        miss_ready;
    logic [7:0]  miss_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] exp_mem [512];
    logic       exp_page;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_xram_ctrl u_aux_xram_ctrl (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_wide (req_wide), .req_iap (req_iap),
        .req_write (req_write), .req_addr16 (req_addr16), .req_ptr (req_ptr),
        .req_wdata (req_wdata), .rsp_ready (rsp_ready), .rsp_rdata (rsp_rdata),
        .sfr_addr (sfr_addr), .sfr_we (sfr_we), .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata), .miss_valid (miss_valid), .miss_write (miss_write),
        .miss_addr (miss_addr), .miss_wdata (miss_wdata), .miss_ready (miss_ready),
        .miss_rdata (miss_rdata)
    );

    function automatic bit exp_hit(input bit wide, input bit mode, input logic [15:0] a16);
        if (!wide) return 1'b1;
        return !mode && (a16 < 16'h0200);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0; sfr_addr = 8'h86;
        if (a == 8'h86) exp_page = d[0];
    endtask

    task automatic sfr_check(input logic [7:0] a, input string tag);
        logic [7:0] e;
        e = (a == 8'h86) ? {7'b0, exp_page} : 8'h00;
        sfr_addr = a;
        #1;
        chk(sfr_rdata === e, tag, int'(sfr_rdata), int'(e));
        sfr_addr = 8'h86;
    endtask

    task automatic do_access(input bit wide, input bit mode, input logic [15:0] a16,
                             input logic [7:0] a8, input bit wr, input logic [7:0] wd,
                             input int waits, input bit intrude);
        logic [8:0] pa;
        bit         hit;
        logic [7:0] mr;
        hit = exp_hit(wide, mode, a16);
        pa  = wide ? a16[8:0] : {exp_page, a8};
        @(negedge clk);
        req_valid = 1'b1; req_wide = wide; req_iap = mode; req_addr16 = a16;
        req_ptr = a8; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (hit) begin
            // R2 ready one cycle after acceptance; R3/R7 narrow path hits RAM
            chk(rsp_ready === 1'b1 && miss_valid === 1'b0,
                wide ? "R2 ram ready" : "R3 R7 narrow ram ready", int'(rsp_ready), 1);
            if (!wr) begin
                chk(rsp_rdata === exp_mem[pa], wide ? "R10 read data" : "R3 paged read data",
                    int'(rsp_rdata), int'(exp_mem[pa]));
            end else begin
                exp_mem[pa] = wd;
            end
            @(negedge clk);
            chk(rsp_ready === 1'b0, "R2 ready single pulse", int'(rsp_ready), 0);
        end else begin
            chk(miss_valid === 1'b1 && miss_addr === a16 && miss_write === wr,
                "R4 miss issued", int'(miss_addr), int'(a16));
            if (wr) chk(miss_wdata === wd, "R4 miss wdata", int'(miss_wdata), int'(wd));
            for (int i = 0; i < waits; i++) begin
                if (intrude && i == 0) begin
                    // R8 intruding RAM write while busy
                    req_valid = 1'b1; req_wide = 1'b1; req_iap = 1'b0;
                    req_addr16 = 16'h0005; req_write = 1'b1; req_wdata = ~exp_mem[9'd5];
                end
                @(negedge clk);
                req_valid = 1'b0;
                chk(miss_valid === 1'b1 && rsp_ready === 1'b0 && miss_addr === a16,
                    intrude ? "R8 miss kept while busy" : "R4 miss held",
                    int'(miss_addr), int'(a16));
            end
            mr = 8'($urandom);
            miss_ready = 1'b1; miss_rdata = mr;
            #1;
            chk(rsp_ready === 1'b1, "R5 ready follows miss_ready", int'(rsp_ready), 1);
            if (!wr) chk(rsp_rdata === mr, "R5 miss data", int'(rsp_rdata), int'(mr));
            @(negedge clk);
            miss_ready = 1'b0;
            chk(miss_valid === 1'b0 && rsp_ready === 1'b0, "R5 miss released",
                int'(miss_valid), 0);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; req_valid = 1'b0; req_wide = 1'b0; req_iap = 1'b0; req_write = 1'b0;
        req_addr16 = '0; req_ptr = '0; req_wdata = '0;
        sfr_addr = 8'h86; sfr_we = 1'b0; sfr_wdata = '0;
        miss_ready = 1'b0; miss_rdata = '0;
        exp_page = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(rsp_ready === 1'b0 && miss_valid === 1'b0, "R1 idle after reset",
            int'(rsp_ready), 0);
        sfr_check(8'h86, "R1 page resets to 0");

        // R10 fill the whole RAM through wide writes
        for (int i = 0; i < 512; i++) begin
            do_access(1'b1, 1'b0, 16'(i), 8'h00, 1'b1, 8'($urandom), 0, 1'b0);
        end
        // R2 boundaries
        do_access(1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 0, 1'b0);
        do_access(1'b1, 1'b0, 16'h01FF, 8'h00, 1'b0, 8'h00, 0, 1'b0);
        // R4 boundaries: first address above RAM, and mode set inside RAM range
        do_access(1'b1, 1'b0, 16'h0200, 8'h00, 1'b0, 8'h00, 2, 1'b0);
        do_access(1'b1, 1'b1, 16'h0010, 8'h00, 1'b1, 8'hC3, 1, 1'b0);
        do_access(1'b1, 1'b0, 16'h0010, 8'h00, 1'b0, 8'h00, 0, 1'b0);
        // R8 request during a pending miss is dropped
        do_access(1'b1, 1'b0, 16'h0345, 8'h00, 1'b1, 8'h11, 2, 1'b1);
        do_access(1'b1, 1'b0, 16'h0005, 8'h00, 1'b0, 8'h00, 0, 1'b0);

        // R6 page register
        sfr_write(8'h86, 8'hFF);
        sfr_check(8'h86, "R6 page reads 01h after FFh write");
        sfr_write(8'h87, 8'h00);
        sfr_check(8'h86, "R6 other address leaves page");
        sfr_check(8'h85, "R6 other address reads 0");

        // R3 page 1 and page 0 ends; R7 narrow ignores mode
        do_access(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 0, 1'b0);
        do_access(1'b0, 1'b1, 16'h0000, 8'hFF, 1'b0, 8'h00, 0, 1'b0);
        sfr_write(8'h86, 8'h00);
        do_access(1'b0, 1'b1, 16'h0000, 8'hFF, 1'b1, 8'h9A, 0, 1'b0);
        do_access(1'b1, 1'b0, 16'h00FF, 8'h00, 1'b0, 8'h00, 0, 1'b0);

        // R9 page write on the accepting edge does not affect that access
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = 8'h86; sfr_wdata = 8'h01;
        req_valid = 1'b1; req_wide = 1'b0; req_iap = 1'b0; req_ptr = 8'h33; req_write = 1'b0;
        @(negedge clk);
        sfr_we = 1'b0; req_valid = 1'b0;
        chk(rsp_ready === 1'b1 && rsp_rdata === exp_mem[9'h033], "R9 old page used",
            int'(rsp_rdata), int'(exp_mem[9'h033]));
        exp_page = 1'b1;
        @(negedge clk);
        sfr_check(8'h86, "R9 page updated afterwards");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int          r;
            logic [15:0] a;
            r = int'($urandom % 10);
            if (r == 0) begin
                sfr_write((($urandom % 3) == 0) ? 8'h87 : 8'h86, 8'($urandom));
            end else begin
                if (r < 6)      a = 16'($urandom % 512);
                else if (r < 9) a = 16'(512 + $urandom % 1024);
                else            a = 16'($urandom);
                do_access(1'($urandom), (($urandom % 4) == 0), a, 8'($urandom),
                          1'($urandom), 8'($urandom), int'($urandom % 3), 1'b0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule